// File: doc/BRIEF.md
# Truth-Table Fitness Evaluator

This block grades a candidate combinational circuit against a fixed target: a 2-bit adder whose two 2-bit operands are added modulo 4. It drives each of the 16 possible 4-bit input words onto the candidate, one word at a time, waits for the candidate to settle, and then compares the candidate's 2-bit answer with the adder's answer bit by bit. A wrong answer word still earns credit for each of its bits that happen to be right. The count of correct bits, summed over all 16 words, is the fitness score, with a maximum of 32.

A search engine outside the block loads a candidate and sets the settle delay. It then pulses `start` and waits for `done`. The score and a flag that marks a flawless candidate stay valid until the next run begins. The operand widths are parameters. The default build is the 2-bit adder.

Top module: `tt_fitness_eval`

## Requirements
- R1: After reset, `busy`, `done` and `perfect` are low, and `score` and `stim` are zero.
- R2: A `start` seen high at a clock edge while idle begins a run. From that edge on, `busy` is high, `stim` is 0 and `score` is 0.
- R3: Vectors are driven in ascending order from 0 to 15. Operand A is `stim[3:2]` and operand B is `stim[1:0]`. Each vector is held for `settle`+1 cycles, so `done` rises 16×(`settle`+1) clock edges after the start edge.
- R4: Within each vector's hold time, `resp` is sampled only in the last cycle, after `settle` full cycles of settling. A candidate whose answer lags its input by up to `settle` cycles scores as if it had no lag.
- R5: For each vector, a point is earned for each bit i in 0..1 where `resp[i]` equals bit i of (A+B) mod 4.
- R6: At the end of a run, `score` equals the sum of those points over all 16 vectors, and it never exceeds 32.
- R7: `done` is a single-cycle pulse. It comes in the cycle in which `busy` has just fallen and the final score is shown.
- R8: While idle, `score` does not change until the next accepted `start`, whatever `resp` does.
- R9: A `start` received while `busy` is high is ignored. The run keeps its order, length and score.
- R10: `perfect` is high exactly when `score` is 32, which can only be true while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new evaluation run |
| settle | input | 4 | Settle cycles waited before each sample |
| stim | output | 4 | Vector driven to the candidate (A in [3:2], B in [1:0]) |
| resp | input | 2 | Candidate's answer |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| score | output | 6 | Correct output bits over the last run |
| perfect | output | 1 | Score equals the maximum |

## Verification
The assertions assume that `settle` is held constant for the whole of a run. They also assume that `start` is a clean synchronous level, which may arrive at any time, including in the middle of a run. The bench changes `settle` only between runs. It pulses `start` both while idle and in the middle of a run. The candidate is modelled as an adder with an error mask drawn from `$urandom` and an input delay of its own; the delay stays at or below the settle time, apart from one directed case that goes exactly one cycle beyond it.

// File: rtl/tt_fit_pkg.sv
package tt_fit_pkg;
   typedef enum logic {
      EV_IDLE = 1'b0,
      EV_RUN  = 1'b1
   } ev_state_e;
endpackage

// File: rtl/tt_seq.sv
module tt_seq #(
   parameter int IN_W     = 4,
   parameter int SETTLE_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [SETTLE_W-1:0] settle,
   output logic                busy,
   output logic [IN_W-1:0]     vec,
   output logic                clr,
   output logic                sample,
   output logic                finish
);
   import tt_fit_pkg::*;

   localparam logic [IN_W-1:0] LAST_VEC = '1;

   ev_state_e           state_q;
   logic [SETTLE_W-1:0] wait_q;

   assign busy   = (state_q == EV_RUN);
   assign clr    = (state_q == EV_IDLE) && start;
   assign sample = busy && (wait_q == '0);
   assign finish = sample && (vec == LAST_VEC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= EV_IDLE;
         vec     <= '0;
         wait_q  <= '0;
      end else begin
         case (state_q)
            EV_IDLE: begin
               if (start) begin
                  state_q <= EV_RUN;
                  vec     <= '0;
                  wait_q  <= settle;
               end
            end
            default: begin
               if (wait_q != '0) begin
                  wait_q <= wait_q - 1'b1;
               end else if (vec == LAST_VEC) begin
                  state_q <= EV_IDLE;
               end else begin
                  vec    <= vec + 1'b1;
                  wait_q <= settle;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/tt_match.sv
module tt_match #(
   parameter int OP_W  = 2,
   parameter int HIT_W = 2
) (
   input  logic [2*OP_W-1:0] stim,
   input  logic [OP_W-1:0]   resp,
   output logic [HIT_W-1:0]  hits
);
   logic [OP_W-1:0] golden;
   logic [OP_W-1:0] agree;

   assign golden = stim[2*OP_W-1:OP_W] + stim[OP_W-1:0];

   for (genvar b = 0; b < OP_W; b++) begin : g_bit
      assign agree[b] = (golden[b] == resp[b]);
   end

   always_comb begin
      hits = '0;
      for (int i = 0; i < OP_W; i++) begin
         hits = hits + HIT_W'(agree[i]);
      end
   end
endmodule

// File: rtl/tt_acc.sv
module tt_acc #(
   parameter int HIT_W   = 2,
   parameter int SCORE_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               add,
   input  logic [HIT_W-1:0]   hits,
   output logic [SCORE_W-1:0] total
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         total <= '0;
      end else if (clr) begin
         total <= '0;
      end else if (add) begin
         total <= total + SCORE_W'(hits);
      end
   end
endmodule

// File: rtl/tt_fitness_eval.sv
module tt_fitness_eval #(
   parameter int OP_W     = 2,
   parameter int SETTLE_W = 4,
   localparam int IN_W      = 2 * OP_W,
   localparam int N_VEC     = 1 << IN_W,
   localparam int MAX_SCORE = OP_W * N_VEC,
   localparam int SCORE_W   = $clog2(MAX_SCORE + 1),
   localparam int HIT_W     = $clog2(OP_W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [SETTLE_W-1:0] settle,
   output logic [IN_W-1:0]     stim,
   input  logic [OP_W-1:0]     resp,
   output logic                busy,
   output logic                done,
   output logic [SCORE_W-1:0]  score,
   output logic                perfect
);
   if (OP_W < 1 || OP_W > 6) begin : g_bad_op_w
      $error("tt_fitness_eval: OP_W must lie in 1..6");
   end
   if (SETTLE_W < 1) begin : g_bad_settle_w
      $error("tt_fitness_eval: SETTLE_W must be at least 1");
   end

   logic             clr;
   logic             sample;
   logic             finish;
   logic [HIT_W-1:0] hits;

   tt_seq #(.IN_W(IN_W), .SETTLE_W(SETTLE_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .settle (settle),
      .busy   (busy),
      .vec    (stim),
      .clr    (clr),
      .sample (sample),
      .finish (finish)
   );

   tt_match #(.OP_W(OP_W), .HIT_W(HIT_W)) u_match (
      .stim (stim),
      .resp (resp),
      .hits (hits)
   );

   tt_acc #(.HIT_W(HIT_W), .SCORE_W(SCORE_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .add   (sample),
      .hits  (hits),
      .total (score)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= finish;
   end

   assign perfect = (score == SCORE_W'(MAX_SCORE));
endmodule

// File: rtl/tt_fitness_chk.sv
module tt_fitness_chk #(
   parameter int IN_W      = 4,
   parameter int SCORE_W   = 6,
   parameter int MAX_SCORE = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [IN_W-1:0]    stim,
   input logic               busy,
   input logic               done,
   input logic [SCORE_W-1:0] score,
   input logic               perfect
);
   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && stim == '0 && score == '0));

   // R3
   stim_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (stim == $past(stim) || stim == IN_W'($past(stim) + 1'b1)));

   // R6
   score_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      score <= SCORE_W'(MAX_SCORE));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R8
   score_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(score));

   // R9
   busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && stim != '1) |=> busy);

   // R10
   perfect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      perfect |-> !busy);
endmodule

bind tt_fitness_eval tt_fitness_chk #(
   .IN_W      (IN_W),
   .SCORE_W   (SCORE_W),
   .MAX_SCORE (MAX_SCORE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .stim    (stim),
   .busy    (busy),
   .done    (done),
   .score   (score),
   .perfect (perfect)
);

// File: tb/tt_fitness_eval_tb.sv
module tt_fitness_eval_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] settle = 4'd0;
   logic [3:0] stim;
   logic [1:0] resp;
   logic       busy, done, perfect;
   logic [5:0] score;

   int         checks = 0;
   int         errors = 0;
   logic [31:0] mask = 32'd0;
   int         dly = 0;
   logic [3:0] pipe [0:7];
   logic [3:0] dsel;

   always #4 clk = ~clk;

   tt_fitness_eval u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .settle(settle),
      .stim(stim), .resp(resp), .busy(busy), .done(done),
      .score(score), .perfect(perfect)
   );

   // candidate: adder with error mask, input delayed by dly cycles
   always @(posedge clk) begin
      pipe[0] <= stim;
      for (int i = 1; i < 8; i++) pipe[i] <= pipe[i-1];
   end

   always_comb begin
      dsel = (dly == 0) ? stim : pipe[dly-1];
      resp = 2'(dsel[3:2] + dsel[1:0]) ^ mask[2*dsel +: 2];
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_score(input logic [31:0] m, input bit shifted,
                                    input logic [3:0] idle_v);
      int sc = 0;
      for (int v = 0; v < 16; v++) begin
         logic [3:0] vv;
         logic [3:0] src;
         logic [1:0] got;
         logic [1:0] want;
         vv   = 4'(v);
         src  = shifted ? ((v == 0) ? idle_v : 4'(v - 1)) : vv;
         got  = 2'(src[3:2] + src[1:0]) ^ m[2*src +: 2];
         want = 2'(vv[3:2] + vv[1:0]);
         for (int b = 0; b < 2; b++) if (got[b] == want[b]) sc++;
      end
      return sc;
   endfunction

   task automatic run_eval(input int s, input int exp_sc, input bit poke, input string tag);
      int cyc = 0;
      bit bad_order = 0;
      @(negedge clk);
      settle = 4'(s);
      start  = 1'b1;
      @(negedge clk);
      start  = 1'b0;
      chk({"R2 busy ", tag}, int'(busy), 1);
      chk({"R2 stim/score clear ", tag}, int'(stim) + int'(score), 0);
      while (!done && cyc < 2000) begin
         if (busy && int'(stim) != cyc / (s + 1)) bad_order = 1;
         start = (poke && cyc == 5);
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      chk({"R3 vector order ", tag}, int'(bad_order), 0);
      chk({"R3 run length ", tag}, cyc, 16 * (s + 1));
      chk({"R5 R6 score ", tag}, int'(score), exp_sc);
      chk({"R10 perfect ", tag}, int'(perfect), int'(exp_sc == 32));
      chk({"R7 busy low at done ", tag}, int'(busy), 0);
      @(negedge clk);
      chk({"R7 done one cycle ", tag}, int'(done), 0);
      mask = ~mask;
      repeat (6) @(negedge clk);
      chk({"R8 score held ", tag}, int'(score), exp_sc);
      mask = ~mask;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 score", int'(score), 0);
      chk("R1 stim", int'(stim), 0);
      chk("R1 perfect", int'(perfect), 0);
      rst_n = 1'b1;
      @(negedge clk);

      mask = 32'd0; dly = 0;
      run_eval(0, 32, 0, "exact adder");

      mask = 32'hFFFF_FFFF; dly = 0;
      run_eval(0, 0, 0, "all bits wrong");

      mask = 32'h0000_0400; dly = 0;
      run_eval(1, 31, 0, "single bit wrong");

      for (int k = 0; k < 6; k++) begin
         int s;
         s    = int'($urandom_range(5, 0));
         dly  = int'($urandom_range(s, 0));
         mask = $urandom();
         run_eval(s, exp_score(mask, 0, 4'hF), 0, "random");
      end

      // R4: candidate lag equal to settle is absorbed
      mask = 32'd0; dly = 3;
      run_eval(3, 32, 0, "R4 lag equals settle");

      // R4: lag one beyond settle samples the previous vector's answer
      mask = 32'd0; dly = 4;
      run_eval(3, exp_score(32'd0, 1, 4'hF), 0, "R4 lag past settle");

      // R9: start pulsed mid-run
      dly = 0; mask = $urandom();
      run_eval(2, exp_score(mask, 0, 4'hF), 1, "R9 start while busy");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule